// File: doc/BRIEF.md
# Hibernate Mode Entry Controller

This block owns the single 32-bit control word that moves a chip into its deepest low-power state and back out of it. Software writes the word over a simple register bus; the block checks a key byte, counts how many times in a row the very same value has been written, and raises its freeze and entry outputs in stages: a freeze-prepare warning to always-on peripherals from the first write, an IO freeze from the second and the hibernate entry (with supply supervision switched off) from the third. Any differing write restarts the count, so a stray store cannot drop the chip into hibernate.

While the chip is hibernating the block watches an RTC alarm, a watchdog event and four wake pins, each gated by its own enable and, for the pins, a selectable active level. A wake ends the hibernate state but keeps the software token byte and the freeze bit, so firmware can tell a wake from a cold start and release the IOs when it is ready. The word survives the general reset whenever its freeze bit is set; only the hard-reset pin clears it unconditionally.

Top module: `hib_entry_ctrl`

## Requirements
- R1: An active-low `hard_rst_n` clears the whole word and all outputs to 0. `bus_rdata` always shows the stored word: token in bits 7:0, key in 15:8, freeze in bit 17, RTC wake enable in 18, watchdog wake enable in 19, pin polarities in 23:20 (bit 20+n, 1 = active high), pin enables in 27:24 (bit 24+n, 1 = pin n may wake), entry block in bit 30, hibernate request in bit 31; bits 16, 28 and 29 read 0.
- R2: The IO freeze and hibernate entry outputs can only assert when the stored key byte (bits 15:8) equals 0x3A.
- R3: `freeze_prep` equals the stored bit 17 and so asserts on the first write that sets it, whatever the key byte holds.
- R4: With key 0x3A and bit 31 set, `io_freeze` asserts after the second consecutive identical write and not after the first.
- R5: With key 0x3A, bit 31 set and bit 30 clear, `hib_enter` and `supv_disable` assert after the third consecutive identical write; a write of a different value restarts the count at one and drops both staged outputs.
- R6: `gen_rst` clears the word, the count and the outputs when bit 17 is 0; when bit 17 is 1 it has no effect. An effective `gen_rst` wins over a write in the same cycle.
- R7: While `hib_enter` is high, a wake occurs on `rtc_alarm` with bit 18 set, on `wdt_alarm` with bit 19 set, or on any wake pin whose enable bit is set and whose level equals its polarity bit; disabled sources do nothing.
- R8: A wake clears bit 31, `hib_enter` and `supv_disable` on the next edge, keeps `io_freeze`, and makes the next write count as the first of a new sequence. A write in the same cycle takes priority over a wake.
- R9: While bit 30 is set, `hib_enter` stays low however many identical writes occur.
- R10: The token byte and bit 17 are kept through a wake and through an ignored `gen_rst`; the hard reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Master hard reset, asynchronous, active low |
| gen_rst | input | 1 | General reset request, synchronous, active high |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Current register contents |
| rtc_alarm | input | 1 | RTC alarm event |
| wdt_alarm | input | 1 | Watchdog event |
| wake_pin | input | 4 | Wake pin levels |
| freeze_prep | output | 1 | Warns always-on peripherals of a coming freeze |
| io_freeze | output | 1 | Freezes IO configuration and state |
| hib_enter | output | 1 | Requests entry into hibernate |
| supv_disable | output | 1 | Disables supply supervision during hibernate |

## Verification
A wrong write count shows up one edge after the offending write: `io_freeze` or `hib_enter` rises one write too early, too late, or survives a differing write. A corrupted stored word is visible at once on `bus_rdata` and, through the key and block bits, on the entry outputs; a wake that is lost or misdirected leaves `hib_enter` high one edge after the enabled source fired, or drops it when a disabled source fired. Errors in reset protection appear in the cycle after `gen_rst`, as a token that vanished or a word that survived.

// File: rtl/hib_pkg.sv
package hib_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_PINS = 4;

  // Layout of the control word; bit positions are decoded by software.
  typedef struct packed {
    logic                hib;       // 31 hibernate request
    logic                hib_block; // 30 entry block
    logic [1:0]          rsv_hi;    // 29:28
    logic [NUM_PINS-1:0] pin_en;    // 27:24
    logic [NUM_PINS-1:0] pin_pol;   // 23:20
    logic                wdt_en;    // 19
    logic                rtc_en;    // 18
    logic                freeze;    // 17
    logic                rsv_lo;    // 16
    logic [7:0]          key;       // 15:8
    logic [7:0]          token;     // 7:0
  } hib_word_t;

  localparam logic [WORD_W-1:0] WR_MASK = 32'hCFFE_FFFF;

  function automatic logic key_matches(input logic [7:0] key, input logic [7:0] ref_key);
    return key == ref_key;
  endfunction

  // A pin fires when enabled and its level equals its polarity bit.
  function automatic logic pin_fires(input logic en, input logic pol, input logic lvl);
    return en && (lvl == pol);
  endfunction

  function automatic logic stage_reached(input int unsigned run, input int unsigned need);
    return run >= need;
  endfunction

endpackage

// File: rtl/hib_write_seq.sv
module hib_write_seq #(
  parameter int unsigned SAT = 3,
  parameter int unsigned DW  = 32,
  localparam int unsigned CW = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] run_next
);

  logic [DW-1:0] last_q;
  logic [CW-1:0] run_q;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (c >= CW'(SAT)) ? c : c + 1'b1;
  endfunction

  // Length of the identical-write run if the current write is taken.
  always_comb begin
    if (run_q != '0 && wdata == last_q) run_next = sat_inc(run_q);
    else                                run_next = CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= '0;
    end else if (clr) begin
      run_q  <= '0;
    end else if (we) begin
      run_q  <= run_next;
      last_q <= wdata;
    end
  end

endmodule

// File: rtl/hib_stage_ctrl.sv
module hib_stage_ctrl #(
  parameter logic [7:0]  KEY           = 8'h3A,
  parameter int unsigned FREEZE_WRITES = 2,
  parameter int unsigned ENTRY_WRITES  = 3,
  localparam int unsigned CW = $clog2(ENTRY_WRITES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic          wake,
  input  logic [7:0]    w_key,
  input  logic          w_hib,
  input  logic          w_block,
  input  logic [CW-1:0] run_next,
  output logic          io_freeze,
  output logic          hib_enter
);
  import hib_pkg::*;

  logic armed_w;
  logic io_d;
  logic en_d;

  assign armed_w = key_matches(w_key, KEY) && w_hib;
  assign io_d    = armed_w && stage_reached(int'(run_next), FREEZE_WRITES);
  assign en_d    = armed_w && !w_block && stage_reached(int'(run_next), ENTRY_WRITES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_freeze <= 1'b0;
      hib_enter <= 1'b0;
    end else if (clr) begin
      io_freeze <= 1'b0;
      hib_enter <= 1'b0;
    end else if (we) begin
      io_freeze <= io_d;
      hib_enter <= en_d;
    end else if (wake) begin
      hib_enter <= 1'b0;
    end
  end

endmodule

// File: rtl/hib_wake_detect.sv
module hib_wake_detect #(
  parameter int unsigned NP = 4
) (
  input  logic          armed,
  input  logic          rtc_en,
  input  logic          wdt_en,
  input  logic [NP-1:0] pin_en,
  input  logic [NP-1:0] pin_pol,
  input  logic          rtc_alarm,
  input  logic          wdt_alarm,
  input  logic [NP-1:0] pin_lvl,
  output logic          wake
);
  import hib_pkg::*;

  logic [NP-1:0] pin_hit;

  for (genvar i = 0; i < NP; i++) begin : g_pin
    assign pin_hit[i] = pin_fires(pin_en[i], pin_pol[i], pin_lvl[i]);
  end

  assign wake = armed && ((rtc_en && rtc_alarm) || (wdt_en && wdt_alarm) || (|pin_hit));

endmodule

// File: rtl/hib_entry_ctrl.sv
module hib_entry_ctrl #(
  parameter logic [7:0]  KEY           = 8'h3A,
  parameter int unsigned FREEZE_WRITES = 2,
  parameter int unsigned ENTRY_WRITES  = 3
) (
  input  logic        clk,
  input  logic        hard_rst_n,
  input  logic        gen_rst,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rtc_alarm,
  input  logic        wdt_alarm,
  input  logic [3:0]  wake_pin,
  output logic        freeze_prep,
  output logic        io_freeze,
  output logic        hib_enter,
  output logic        supv_disable
);
  import hib_pkg::*;

  localparam int unsigned CW = $clog2(ENTRY_WRITES + 1);

  hib_word_t     cfg_q;
  hib_word_t     wcfg;
  logic          rst_apply;
  logic          we_apply;
  logic          wake_hit;
  logic          wake_apply;
  logic [CW-1:0] run_next;

  assign wcfg       = hib_word_t'(bus_wdata & WR_MASK);
  // General reset only acts while the word is not frozen.
  assign rst_apply  = gen_rst && !cfg_q.freeze;
  assign we_apply   = bus_we && !rst_apply;
  assign wake_apply = wake_hit && !bus_we && !rst_apply;

  hib_write_seq #(.SAT(ENTRY_WRITES), .DW(WORD_W)) u_seq (
    .clk      (clk),
    .rst_n    (hard_rst_n),
    .clr      (rst_apply || wake_apply),
    .we       (we_apply),
    .wdata    (bus_wdata),
    .run_next (run_next)
  );

  hib_stage_ctrl #(
    .KEY(KEY), .FREEZE_WRITES(FREEZE_WRITES), .ENTRY_WRITES(ENTRY_WRITES)
  ) u_stage (
    .clk       (clk),
    .rst_n     (hard_rst_n),
    .clr       (rst_apply),
    .we        (we_apply),
    .wake      (wake_apply),
    .w_key     (wcfg.key),
    .w_hib     (wcfg.hib),
    .w_block   (wcfg.hib_block),
    .run_next  (run_next),
    .io_freeze (io_freeze),
    .hib_enter (hib_enter)
  );

  hib_wake_detect #(.NP(NUM_PINS)) u_wake (
    .armed     (hib_enter),
    .rtc_en    (cfg_q.rtc_en),
    .wdt_en    (cfg_q.wdt_en),
    .pin_en    (cfg_q.pin_en),
    .pin_pol   (cfg_q.pin_pol),
    .rtc_alarm (rtc_alarm),
    .wdt_alarm (wdt_alarm),
    .pin_lvl   (wake_pin),
    .wake      (wake_hit)
  );

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      cfg_q <= '0;
    end else if (rst_apply) begin
      cfg_q <= '0;
    end else if (we_apply) begin
      cfg_q <= wcfg;
    end else if (wake_apply) begin
      cfg_q.hib <= 1'b0;
    end
  end

  assign bus_rdata    = cfg_q;
  assign freeze_prep  = cfg_q.freeze;
  assign supv_disable = hib_enter;

endmodule

// File: rtl/hib_entry_ctrl_chk.sv
module hib_entry_ctrl_chk #(
  parameter logic [7:0] KEY = 8'h3A
) (
  input logic        clk,
  input logic        hard_rst_n,
  input logic        gen_rst,
  input logic        bus_we,
  input logic        wr_freeze,
  input logic [31:0] bus_rdata,
  input logic        freeze_prep,
  input logic        io_freeze,
  input logic        hib_enter,
  input logic        supv_disable,
  input logic        wake_apply,
  input logic        rst_apply
);

  AST_ENTER_KEYED: assert property (@(posedge clk) disable iff (!hard_rst_n)
    hib_enter |-> (bus_rdata[15:8] == KEY) && bus_rdata[31]); // R2

  AST_ENTER_AFTER_FREEZE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(hib_enter) |-> $past(io_freeze)); // R5

  AST_SUPV_NEEDS_FREEZE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    supv_disable |-> io_freeze); // R5

  AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (!hard_rst_n)
    bus_rdata[30] |-> !hib_enter); // R9

  AST_PREP_FROM_WRITE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (bus_we && !rst_apply) |=> (freeze_prep == $past(wr_freeze))); // R3

  AST_WAKE_EXITS: assert property (@(posedge clk) disable iff (!hard_rst_n)
    wake_apply |=> (!hib_enter && !bus_rdata[31] && $stable(io_freeze))); // R8

  AST_WAKE_KEEPS_TOKEN: assert property (@(posedge clk) disable iff (!hard_rst_n)
    wake_apply |=> ($stable(bus_rdata[7:0]) && $stable(bus_rdata[17]))); // R10

  AST_FROZEN_IGNORES_RST: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (gen_rst && bus_rdata[17] && !bus_we && !wake_apply) |=> $stable(bus_rdata)); // R6

endmodule

bind hib_entry_ctrl hib_entry_ctrl_chk #(.KEY(KEY)) u_chk (
  .clk          (clk),
  .hard_rst_n   (hard_rst_n),
  .gen_rst      (gen_rst),
  .bus_we       (bus_we),
  .wr_freeze    (bus_wdata[17]),
  .bus_rdata    (bus_rdata),
  .freeze_prep  (freeze_prep),
  .io_freeze    (io_freeze),
  .hib_enter    (hib_enter),
  .supv_disable (supv_disable),
  .wake_apply   (wake_apply),
  .rst_apply    (rst_apply)
);

// File: tb/hib_entry_ctrl_test.sv
`timescale 1ns/1ps
module hib_entry_ctrl_test;

  localparam logic [31:0] WMASK = 32'hCFFE_FFFF;
  localparam logic [31:0] W_V = 32'h8006_3AA5; // hib, rtc wake, freeze, key, token A5
  localparam logic [31:0] W_P = 32'h8402_3A11; // hib, pin2 enabled active low, freeze
  localparam logic [31:0] W_K = 32'h8002_2B00; // wrong key
  localparam logic [31:0] W_D = 32'hC002_3A00; // entry block set
  localparam logic [31:0] W_W = 32'h800A_3A00; // watchdog wake only

  logic        clk = 1'b0;
  logic        hard_rst_n = 1'b0;
  logic        gen_rst = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rtc_alarm = 1'b0;
  logic        wdt_alarm = 1'b0;
  logic [3:0]  wake_pin = 4'hF;
  logic        freeze_prep, io_freeze, hib_enter, supv_disable;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m_reg;
  logic [31:0] m_last;
  int          m_cnt;
  logic        m_io, m_en;

  always #4 clk = ~clk;

  hib_entry_ctrl uut (
    .clk(clk), .hard_rst_n(hard_rst_n), .gen_rst(gen_rst),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rtc_alarm(rtc_alarm), .wdt_alarm(wdt_alarm), .wake_pin(wake_pin),
    .freeze_prep(freeze_prep), .io_freeze(io_freeze),
    .hib_enter(hib_enter), .supv_disable(supv_disable)
  );

  function automatic logic f_key_ok(input logic [31:0] w);
    return w[15:8] == 8'h3A;
  endfunction

  function automatic logic f_wake(input logic [31:0] w, input logic rtc, input logic wdt,
                                  input logic [3:0] pins);
    logic hit = (w[18] & rtc) | (w[19] & wdt);
    for (int i = 0; i < 4; i++) if (w[24+i] && (pins[i] == w[20+i])) hit = 1'b1;
    return hit;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "rdata", bus_rdata, m_reg);
    chk(req, "freeze_prep", 32'(freeze_prep), 32'(m_reg[17]));
    chk(req, "io_freeze", 32'(io_freeze), 32'(m_io));
    chk(req, "hib_enter", 32'(hib_enter), 32'(m_en));
    chk(req, "supv_disable", 32'(supv_disable), 32'(m_en));
  endtask

  task automatic m_clear();
    m_reg = '0; m_cnt = 0; m_io = 1'b0; m_en = 1'b0; m_last = '0;
  endtask

  task automatic hard_reset(input string req);
    hard_rst_n = 1'b0;
    bus_we = 1'b0; gen_rst = 1'b0; rtc_alarm = 1'b0; wdt_alarm = 1'b0;
    #3;
    m_clear();
    @(negedge clk);
    hard_rst_n = 1'b1;
    chk_all(req);
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs checked.
  task automatic step(input logic we, input logic [31:0] wd, input logic gr, input logic rtc,
                      input logic wdt, input logic [3:0] pins, input string req);
    logic rst_e, wk;
    int   nc;
    bus_we = we; bus_wdata = wd; gen_rst = gr;
    rtc_alarm = rtc; wdt_alarm = wdt; wake_pin = pins;
    rst_e = gr && !m_reg[17];
    wk    = m_en && f_wake(m_reg, rtc, wdt, pins) && !we && !rst_e;
    @(posedge clk);
    if (rst_e) begin
      m_reg = '0; m_cnt = 0; m_io = 1'b0; m_en = 1'b0;
    end else if (we) begin
      nc = (m_cnt != 0 && wd == m_last) ? ((m_cnt >= 3) ? 3 : m_cnt + 1) : 1;
      m_cnt  = nc;
      m_last = wd;
      m_reg  = wd & WMASK;
      m_io   = f_key_ok(m_reg) && m_reg[31] && nc >= 2;
      m_en   = f_key_ok(m_reg) && m_reg[31] && !m_reg[30] && nc >= 3;
    end else if (wk) begin
      m_reg[31] = 1'b0; m_en = 1'b0; m_cnt = 0;
    end
    @(negedge clk);
    bus_we = 1'b0; gen_rst = 1'b0; rtc_alarm = 1'b0; wdt_alarm = 1'b0;
    chk_all(req);
  endtask

  task automatic wr(input logic [31:0] wd, input string req);
    step(1'b1, wd, 1'b0, 1'b0, 1'b0, wake_pin, req);
  endtask

  task automatic idle(input logic gr, input logic rtc, input logic wdt, input logic [3:0] pins,
                      input string req);
    step(1'b0, '0, gr, rtc, wdt, pins, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_clear();
    @(negedge clk);
    hard_reset("R1");

    // Staged entry with the correct key
    wr(W_V, "R3");
    chk("R4", "io_freeze after one write", 32'(io_freeze), 32'd0);
    wr(W_V, "R4");
    chk("R4", "io_freeze after two writes", 32'(io_freeze), 32'd1);
    chk("R5", "hib_enter after two writes", 32'(hib_enter), 32'd0);
    wr(W_V, "R5");
    chk("R5", "hib_enter after three writes", 32'(hib_enter), 32'd1);
    idle(1'b1, 1'b0, 1'b0, 4'hF, "R6");
    chk("R6", "frozen word kept", bus_rdata, W_V);
    idle(1'b0, 1'b1, 1'b0, 4'hF, "R7");
    chk("R8", "hib_enter after rtc wake", 32'(hib_enter), 32'd0);
    chk("R10", "token after wake", 32'(bus_rdata[7:0]), 32'hA5);
    chk("R8", "io_freeze kept after wake", 32'(io_freeze), 32'd1);

    // Broken sequence then restart
    wr(W_V, "R8");
    chk("R8", "first write after wake counts one", 32'(io_freeze), 32'd0);
    wr(W_V, "R5");
    wr(W_V ^ 32'h1, "R5");
    chk("R5", "differing write drops io_freeze", 32'(io_freeze), 32'd0);
    wr(W_P, "R5"); wr(W_P, "R5"); wr(W_P, "R5");
    idle(1'b0, 1'b0, 1'b0, 4'hF, "R7");
    chk("R7", "inactive pin holds entry", 32'(hib_enter), 32'd1);
    idle(1'b0, 1'b0, 1'b0, 4'hB, "R7");
    chk("R7", "active-low pin wakes", 32'(hib_enter), 32'd0);
    wake_pin = 4'hF;

    // Wrong key
    wr(W_K, "R3");
    chk("R3", "prep with wrong key", 32'(freeze_prep), 32'd1);
    wr(W_K, "R2"); wr(W_K, "R2");
    chk("R2", "no entry with wrong key", 32'(hib_enter), 32'd0);
    chk("R2", "no io freeze with wrong key", 32'(io_freeze), 32'd0);

    // Entry block
    wr(W_D, "R9"); wr(W_D, "R9"); wr(W_D, "R9"); wr(W_D, "R9");
    chk("R9", "blocked entry", 32'(hib_enter), 32'd0);

    // Watchdog only
    wr(W_W, "R7"); wr(W_W, "R7"); wr(W_W, "R7");
    idle(1'b0, 1'b1, 1'b0, 4'hF, "R7");
    chk("R7", "disabled rtc ignored", 32'(hib_enter), 32'd1);
    idle(1'b0, 1'b0, 1'b1, 4'hF, "R7");
    chk("R7", "watchdog wakes", 32'(hib_enter), 32'd0);

    // General reset without freeze, and priority over a write
    wr(32'h0000_3A77, "R6");
    idle(1'b1, 1'b0, 1'b0, 4'hF, "R6");
    chk("R6", "unfrozen word cleared", bus_rdata, 32'd0);
    wr(32'h0000_0011, "R6");
    step(1'b1, 32'h0002_0022, 1'b1, 1'b0, 1'b0, 4'hF, "R6");
    chk("R6", "reset beats write", bus_rdata, 32'd0);

    // Reserved bits read zero
    wr(32'hFFFF_FFFF, "R1");
    chk("R1", "reserved bits", bus_rdata & 32'h3001_0000, 32'd0);

    // Token through hard reset
    wr(32'h0002_0055, "R10");
    hard_reset("R10");
    chk("R10", "token after hard reset", 32'(bus_rdata[7:0]), 32'd0);

    // Constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      int          reps;
      case ($urandom_range(0, 5))
        0: w = W_V;
        1: w = W_P;
        2: w = W_K;
        3: w = W_D;
        4: w = W_W;
        default: w = $urandom();
      endcase
      reps = $urandom_range(1, 4);
      for (int r = 0; r < reps; r++) wr(w, "R5");
      for (int k = 0; k < int'($urandom_range(0, 3)); k++)
        idle(($urandom_range(0, 15) == 0), ($urandom_range(0, 7) == 0),
             ($urandom_range(0, 7) == 0), 4'($urandom()), "R8");
      if ($urandom_range(0, 199) == 0) hard_reset("R1");
    end

    finish_run();
  end

endmodule